// File: doc/BRIEF.md
# Pipelined Signed Divider with Configurable Initiation Interval

The block divides a signed `DW`-bit dividend by a signed `VW`-bit divisor and returns a signed quotient together with a remainder. Both operands are first turned into magnitudes. A chain of restoring shift-subtract iterations then produces one quotient bit per clock. The signs are restored at the end. The chain runs `DW + VW` iterations. The first `DW` give the integer quotient, and the integer remainder is captured after the last of them. The extra `VW` iterations give binary fraction bits of `remainder / divisor`.

The iterations are split into `NIT/II` physical stage units. Each unit performs `II` consecutive iterations on one operation. With `II = 1` every iteration has its own hardware and a new operation can enter on every clock. With a larger `II` each unit is reused for `II` clocks, so fewer units are built and operations can enter only every `II` clocks. Latency is `DW + VW` clocks for every value of `II`. The input side uses a valid/ready handshake. The output side gives a one-cycle valid strobe together with the tag that came in with the operation. A per-operation mode input selects which kind of remainder is returned.

Top module: `sdiv_pipe`

## Requirements
- R1: For a nonzero divisor, `out_quot` equals the dividend divided by the divisor, rounded toward zero, as the low `DW` bits of the two's-complement result. The single overflow case, most-negative dividend divided by -1, therefore returns the most-negative value.
- R2: With `in_frac = 0` and a nonzero divisor, `out_rem` equals dividend − quotient × divisor. It is zero or carries the dividend's sign, and its magnitude is below the divisor's magnitude.
- R3: With `in_frac = 1` and a nonzero divisor, `out_rem` is a signed fraction. Its magnitude is floor(|integer remainder| × 2^(VW−1) / |divisor|). It is negated when the dividend and divisor signs differ, so it always matches the sign of the true quotient.
- R4: When the divisor is zero, `out_dz` is 1, `out_quot` is all ones and `out_rem` is zero. For any nonzero divisor, `out_dz` is 0.
- R5: `out_valid` rises exactly `DW + VW` clock edges after the edge at which the operation was accepted (`in_valid && in_ready`).
- R6: After an accepting edge, `in_ready` stays low for `II − 1` cycles and is high again on the next one. Operations are therefore accepted at most once every `II` clocks.
- R7: Results leave in acceptance order, and `out_tag` repeats the `in_tag` given with the same operation.
- R8: While reset is applied and right after it, `in_ready` is 1 and `out_valid` is 0.
- R9: Each accepted operation produces exactly one single-cycle `out_valid` strobe. With `II > 1`, two strobes are never on adjacent cycles.
- R10: An `in_valid` presented while `in_ready` is low is ignored: no result appears with that cycle's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_dividend | input | DW | Signed dividend |
| in_divisor | input | VW | Signed divisor |
| in_frac | input | 1 | Remainder mode: 0 integer, 1 fractional |
| in_tag | input | TW | Caller tag carried with the operation |
| out_valid | output | 1 | One-cycle result strobe |
| out_quot | output | DW | Signed quotient |
| out_rem | output | VW | Signed remainder (integer or fraction per mode) |
| out_dz | output | 1 | Divisor was zero |
| out_tag | output | TW | Tag of the returned operation |

## Verification
The latency and spacing properties assume that the caller never counts an operation as accepted unless `in_ready` was high at that edge. They also assume the block has no output back-pressure, so every result must be taken on the cycle of its strobe. The stimulus holds `in_valid` high all the time. While `in_ready` is low it presents a poison tag, so any illegal acceptance would show up as a stray tag or as broken spacing. Every dividend and divisor pair of an 8-bit by 4-bit build is swept in both remainder modes, at interval 1 and interval 4. This covers the zero divisor, the -8 divisor and the overflowing most-negative ÷ -1 case.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    REM_INTEGER  = 1'b0,
    REM_FRACTION = 1'b1
  } rem_mode_e;
endpackage

// File: rtl/sdiv_iter.sv
// One stage unit: performs II restoring iterations on a held operation.
module sdiv_iter #(
  parameter int DW   = 32,
  parameter int VW   = 16,
  parameter int II   = 1,
  parameter int BASE = 0,
  parameter int MW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [VW-1:0]     ld_rem,
  input  logic [DW+VW-1:0]  ld_sh,
  input  logic [VW-1:0]     ld_dmag,
  input  logic [VW-1:0]     ld_irem,
  input  logic [MW-1:0]     ld_meta,
  output logic              busy,
  output logic              done,
  output logic [VW-1:0]     nx_rem,
  output logic [DW+VW-1:0]  nx_sh,
  output logic [VW-1:0]     nx_dmag,
  output logic [VW-1:0]     nx_irem,
  output logic [MW-1:0]     nx_meta
);
  localparam int NW = DW + VW;
  localparam int CW = (II > 1) ? $clog2(II) : 1;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] rem_q, dmag_q, irem_q;
  logic [NW-1:0] sh_q;
  logic [MW-1:0] meta_q;
  logic [VW:0]   trial, diff;
  logic          take;
  logic          en;

  // one restoring iteration on the held state
  always_comb begin
    trial   = {rem_q, sh_q[NW-1]};
    take    = (trial >= {1'b0, dmag_q});
    diff    = trial - {1'b0, dmag_q};
    nx_rem  = take ? diff[VW-1:0] : trial[VW-1:0];
    nx_sh   = {sh_q[NW-2:0], take};
    nx_dmag = dmag_q;
    nx_meta = meta_q;
    nx_irem = ((BASE + int'(cnt_q)) == DW - 1) ? nx_rem : irem_q;
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == CW'(II - 1));
  assign en   = ld || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (ld) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rem_q  <= ld ? ld_rem  : nx_rem;
      sh_q   <= ld ? ld_sh   : nx_sh;
      dmag_q <= ld ? ld_dmag : nx_dmag;
      irem_q <= ld ? ld_irem : nx_irem;
      meta_q <= ld ? ld_meta : nx_meta;
    end
  end
endmodule

// File: rtl/sdiv_fix.sv
// Sign restoration and special-case selection on the final magnitudes.
module sdiv_fix #(
  parameter int DW = 32,
  parameter int VW = 16
) (
  input  logic [DW+VW-1:0] qbits,
  input  logic [VW-1:0]    irem,
  input  logic             a_neg,
  input  logic             d_neg,
  input  logic             frac,
  input  logic             dz,
  output logic [DW-1:0]    quot,
  output logic [VW-1:0]    rem
);
  import sdiv_pkg::*;
  logic [DW-1:0] qmag;
  logic [VW-1:0] fbits, fmag, rem_int, rem_frc;
  logic          q_neg;

  always_comb begin
    qmag    = qbits[DW+VW-1:VW];
    fbits   = qbits[VW-1:0];
    fmag    = fbits >> 1;
    q_neg   = a_neg ^ d_neg;
    rem_int = a_neg ? -irem : irem;
    rem_frc = q_neg ? -fmag : fmag;
    if (dz) begin
      quot = '1;
      rem  = '0;
    end else begin
      quot = q_neg ? -qmag : qmag;
      rem  = (rem_mode_e'(frac) == REM_FRACTION) ? rem_frc : rem_int;
    end
  end
endmodule

// File: rtl/sdiv_pipe.sv
module sdiv_pipe #(
  parameter int DW = 32,
  parameter int VW = 16,
  parameter int II = 1,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  input  logic [VW-1:0] in_divisor,
  input  logic          in_frac,
  input  logic [TW-1:0] in_tag,
  output logic          out_valid,
  output logic [DW-1:0] out_quot,
  output logic [VW-1:0] out_rem,
  output logic          out_dz,
  output logic [TW-1:0] out_tag
);
  localparam int NW  = DW + VW;
  localparam int NIT = NW;
  localparam int NST = NIT / II;
  localparam int MW  = TW + 4;

  // meta layout: {tag, frac, dz, a_neg, d_neg}
  logic          accept;
  logic          a_neg, d_neg, dz;
  logic [DW-1:0] amag;
  logic [VW-1:0] dmag;
  logic [MW-1:0] meta0;

  logic [NST-1:0]         busy, done;
  logic [NST-1:0][VW-1:0] nx_rem, nx_dmag, nx_irem;
  logic [NST-1:0][NW-1:0] nx_sh;
  logic [NST-1:0][MW-1:0] nx_meta;

  logic [DW-1:0] fq;
  logic [VW-1:0] fr;
  logic [MW-1:0] fmeta;

  logic          ov_q;
  logic [DW-1:0] q_q;
  logic [VW-1:0] r_q;
  logic          dz_q;
  logic [TW-1:0] tag_q;

  always_comb begin
    a_neg  = in_dividend[DW-1];
    d_neg  = in_divisor[VW-1];
    amag   = a_neg ? -in_dividend : in_dividend;
    dmag   = d_neg ? -in_divisor : in_divisor;
    dz     = (in_divisor == '0);
    meta0  = {in_tag, in_frac, dz, a_neg, d_neg};
    in_ready = !busy[0] || done[0];
    accept   = in_valid && in_ready;
  end

  for (genvar k = 0; k < NST; k++) begin : g_st
    if (k == 0) begin : g_head
      sdiv_iter #(.DW(DW), .VW(VW), .II(II), .BASE(0), .MW(MW)) u_it (
        .clk(clk), .rst_n(rst_n), .ld(accept),
        .ld_rem('0), .ld_sh({amag, {VW{1'b0}}}), .ld_dmag(dmag),
        .ld_irem('0), .ld_meta(meta0),
        .busy(busy[k]), .done(done[k]),
        .nx_rem(nx_rem[k]), .nx_sh(nx_sh[k]), .nx_dmag(nx_dmag[k]),
        .nx_irem(nx_irem[k]), .nx_meta(nx_meta[k]));
    end else begin : g_body
      sdiv_iter #(.DW(DW), .VW(VW), .II(II), .BASE(k * II), .MW(MW)) u_it (
        .clk(clk), .rst_n(rst_n), .ld(done[k-1]),
        .ld_rem(nx_rem[k-1]), .ld_sh(nx_sh[k-1]), .ld_dmag(nx_dmag[k-1]),
        .ld_irem(nx_irem[k-1]), .ld_meta(nx_meta[k-1]),
        .busy(busy[k]), .done(done[k]),
        .nx_rem(nx_rem[k]), .nx_sh(nx_sh[k]), .nx_dmag(nx_dmag[k]),
        .nx_irem(nx_irem[k]), .nx_meta(nx_meta[k]));
    end
  end

  assign fmeta = nx_meta[NST-1];

  sdiv_fix #(.DW(DW), .VW(VW)) u_fix (
    .qbits(nx_sh[NST-1]), .irem(nx_irem[NST-1]),
    .a_neg(fmeta[1]), .d_neg(fmeta[0]), .frac(fmeta[3]), .dz(fmeta[2]),
    .quot(fq), .rem(fr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= done[NST-1];
  end

  always_ff @(posedge clk) begin
    if (done[NST-1]) begin
      q_q   <= fq;
      r_q   <= fr;
      dz_q  <= fmeta[2];
      tag_q <= fmeta[MW-1:4];
    end
  end

  assign out_valid = ov_q;
  assign out_quot  = q_q;
  assign out_rem   = r_q;
  assign out_dz    = dz_q;
  assign out_tag   = tag_q;
endmodule

// File: rtl/sdiv_pipe_chk.sv
module sdiv_pipe_chk #(
  parameter int DW = 32,
  parameter int VW = 16,
  parameter int II = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_quot,
  input logic [VW-1:0] out_rem,
  input logic          out_dz
);
  localparam int NIT = DW + VW;
  logic [NIT:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[NIT-1:0], in_valid && in_ready};
  end

  // R5: result strobe follows acceptance by exactly NIT edges
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[NIT]);

  // R6: no second acceptance inside the interval
  p_interval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && II > 1) |=> !in_ready);

  // R9: strobes are single cycle and spaced by the interval
  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && II > 1) |=> !out_valid);

  // R4: divide-by-zero result is fixed
  p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dz) |-> (out_quot == '1 && out_rem == '0));
endmodule

bind sdiv_pipe sdiv_pipe_chk #(.DW(DW), .VW(VW), .II(II)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_quot(out_quot), .out_rem(out_rem),
  .out_dz(out_dz));

// File: tb/sdiv_pipe_test.sv
`timescale 1ns/1ps

module sdiv_pipe_lane #(
  parameter int II = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int DW = 8, VW = 4, TW = 14, NIT = DW + VW, NOPS = 8192;

  logic          in_valid, in_ready, in_frac;
  logic [DW-1:0] in_dividend;
  logic [VW-1:0] in_divisor;
  logic [TW-1:0] in_tag;
  logic          out_valid, out_dz;
  logic [DW-1:0] out_quot;
  logic [VW-1:0] out_rem;
  logic [TW-1:0] out_tag;

  int checks = 0, fails = 0, cyc = 0, nxt_out = 0;
  int acc_cyc [NOPS];

  sdiv_pipe #(.DW(DW), .VW(VW), .II(II), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_frac(in_frac),
    .in_tag(in_tag), .out_valid(out_valid), .out_quot(out_quot),
    .out_rem(out_rem), .out_dz(out_dz), .out_tag(out_tag));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (II=%0d) %s: actual %0d expected %0d", req, II, what, act, exp);
    end
  endtask

  // stimulus
  initial begin
    int waits;
    bit first;
    done_o = 1'b0; in_valid = 1'b0; in_frac = 1'b0;
    in_dividend = '0; in_divisor = '0; in_tag = '0;
    @(posedge rst_n);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    waits = 0;
    first = 1'b1;
    for (int i = 0; i < NOPS; i++) begin
      while (!in_ready) begin
        in_valid = 1'b1;          // R10 poison while not ready
        in_tag = '1;
        in_dividend = 8'h80;
        in_divisor = 4'h1;
        waits++;
        @(negedge clk);
      end
      chk(waits == (first ? 0 : II - 1), "R6", "cycles with in_ready low",
          waits, first ? 0 : II - 1);
      first = 1'b0;
      waits = 0;
      in_valid    = 1'b1;
      in_tag      = TW'(i);
      in_frac     = i[12];
      in_dividend = i[11:4];
      in_divisor  = i[3:0];
      @(negedge clk);
      acc_cyc[i] = cyc;
    end
    in_valid = 1'b0;
    repeat (NIT + 8) @(negedge clk);
    chk(nxt_out == NOPS, "R9", "result count", nxt_out, NOPS);
    done_o = 1'b1;
  end

  // result monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_tag[TW-1]) begin
        chk(1'b0, "R10", "result with poison tag", int'(out_tag), 0);
      end else begin
        logic [TW-1:0] t;
        int a, d, qi, ri, fm, lat;
        logic [DW-1:0] eq;
        logic [VW-1:0] er;
        bit frac;
        t = out_tag;
        a = int'($signed(t[11:4]));
        d = int'($signed(t[3:0]));
        frac = t[12];
        chk(int'(t) == nxt_out, "R7", "result order tag", int'(t), nxt_out);
        lat = cyc - acc_cyc[int'(t)];
        chk(lat == NIT, "R5", "latency", lat, NIT);
        if (d == 0) begin
          chk(out_dz == 1'b1, "R4", "dz flag", int'(out_dz), 1);
          chk(out_quot == 8'hFF, "R4", "quotient on zero divisor", int'(out_quot), 255);
          chk(out_rem == 4'h0, "R4", "remainder on zero divisor", int'(out_rem), 0);
        end else begin
          qi = a / d;
          ri = a % d;
          eq = DW'(qi);
          chk(out_dz == 1'b0, "R4", "dz flag", int'(out_dz), 0);
          chk(out_quot == eq, "R1", "quotient", int'(out_quot), int'(eq));
          if (frac) begin
            fm = ((ri < 0 ? -ri : ri) * 8) / (d < 0 ? -d : d);
            er = VW'(((a < 0) != (d < 0)) ? -fm : fm);
            chk(out_rem == er, "R3", "fractional remainder", int'(out_rem), int'(er));
          end else begin
            er = VW'(ri);
            chk(out_rem == er, "R2", "integer remainder", int'(out_rem), int'(er));
          end
        end
        nxt_out++;
      end
    end
  end
endmodule

module sdiv_pipe_test;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic done_a, done_b;
  bit   timeout = 1'b0;

  always #2 clk = ~clk;

  sdiv_pipe_lane #(.II(1)) lane_ii1 (.clk(clk), .rst_n(rst_n), .done_o(done_a));
  sdiv_pipe_lane #(.II(4)) lane_ii4 (.clk(clk), .rst_n(rst_n), .done_o(done_b));

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int total, bad;
    fork
      wait (done_a && done_b);
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    total = lane_ii1.checks + lane_ii4.checks;
    bad   = lane_ii1.fails + lane_ii4.fails;
    if (timeout) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule